// File: doc/BRIEF.md
# Gate-Command Input Pulse Filter

This block conditions the eight logic inputs of a three-phase gate driver before they reach the drive logic. There are six motor commands (three upper-switch and three lower-switch) and two control inputs (enable and fault clear). Each raw input first crosses into the local clock through a chain of flops. A per-channel filter then passes a new level only after the synchronized input has held it for a set number of consecutive clock cycles. Anything shorter is dropped entirely.

Rising and falling transitions go through the same qualification. An accepted pulse therefore leaves the block with exactly the width it had on entry, only shifted in time. The two channel classes get separate lengths: a long one for the gate commands and a short one for the control pins. Both lengths are fixed at elaboration. With a 100 MHz clock, typical values are 27 cycles for commands and 5 cycles for control.

Top module: `gate_input_conditioner`

## Requirements
- R1: While reset is asserted, all eight filtered outputs are 0, whatever the raw inputs do. They stay 0 in the first cycle after reset is released.
- R2: A pulse on a command input lasting fewer than CMD_LEN clock cycles causes no change on its filtered output.
- R3: A pulse on a command input lasting W >= CMD_LEN cycles appears on its filtered output as a pulse of exactly W cycles.
- R4: The enable and fault-clear channels use CTL_LEN in place of CMD_LEN. A pulse of CTL_LEN-1 cycles is dropped, and a pulse of W >= CTL_LEN cycles comes out W cycles wide.
- R5: Suppose a raw input changes between clock edges and then holds its new level. The filtered output takes that level SYNC_STAGES + LEN clock edges later, where LEN is the channel's filter length. The delay is the same for the rising transition and the falling one.
- R6: A single sample that matches the current output restarts qualification. A train of (LEN-1)-cycle high pulses separated by one low cycle never changes the output.
- R7: A transition on one input leaves all other filtered outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_cmd_raw | input | 3 | Raw upper-switch commands, one bit per phase |
| lo_cmd_raw | input | 3 | Raw lower-switch commands, one bit per phase |
| en_raw | input | 1 | Raw enable input |
| fclr_raw | input | 1 | Raw fault-clear input |
| hi_cmd | output | 3 | Filtered upper-switch commands |
| lo_cmd | output | 3 | Filtered lower-switch commands |
| en_filt | output | 1 | Filtered enable |
| fclr_filt | output | 1 | Filtered fault clear |

## Verification
The bench drives pulses one cycle below, exactly at and above each class's length.

- A counter compared against the wrong terminal value would pass a pulse one cycle short, or drop the one that should pass.
- A design that qualified only the rising edge would show a stretched or clipped output width.
- Mixing up the two lengths would make the control channels behave like commands.
- A filter that kept counting across a one-cycle return to the output level would let the noise train through.

The exact rise and fall delays are measured against SYNC_STAGES + LEN. Every run also checks that the untouched channels stay quiet.

// File: rtl/gate_filt_pkg.sv
package gate_filt_pkg;
  localparam int unsigned NUM_CMD = 6;
  localparam int unsigned NUM_CTL = 2;
  localparam int unsigned NUM_CH  = NUM_CMD + NUM_CTL;

  // counter bits needed to hold values 0 .. len-1
  function automatic int unsigned cnt_bits(int unsigned len);
    return (len < 2) ? 1 : $clog2(len);
  endfunction

  // qualification completes on the sample that makes the run len long
  function automatic logic run_complete(int unsigned run_so_far, int unsigned len);
    return (run_so_far + 1) >= len;
  endfunction

  // filter length for a channel index: commands first, then control
  function automatic int unsigned chan_len(int unsigned ch, int unsigned cmd_len,
                                           int unsigned ctl_len);
    return (ch < NUM_CMD) ? cmd_len : ctl_len;
  endfunction
endpackage

// File: rtl/in_sync.sv
module in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
  import gate_filt_pkg::*;
#(
  parameter int unsigned LEN = 27
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  output logic q
);
  localparam int unsigned CW = cnt_bits(LEN);

  logic [CW-1:0] run;
  logic          differs;
  logic          accept;

  assign differs = (smp != q);
  assign accept  = differs && run_complete(int'(run), LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
      q   <= 1'b0;
    end else if (!differs || accept) begin
      run <= '0;
      if (accept) q <= smp;
    end else begin
      run <= run + 1'b1;
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run) < int'(LEN));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp == q) |=> (run == '0));

  // R5
  flip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> ($past(smp) != $past(q)));

  // R1
  reset_low_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (q == 1'b0));
endmodule

// File: rtl/gate_input_conditioner.sv
module gate_input_conditioner
  import gate_filt_pkg::*;
#(
  parameter int unsigned CMD_LEN     = 27,
  parameter int unsigned CTL_LEN     = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hi_cmd_raw,
  input  logic [2:0] lo_cmd_raw,
  input  logic       en_raw,
  input  logic       fclr_raw,
  output logic [2:0] hi_cmd,
  output logic [2:0] lo_cmd,
  output logic       en_filt,
  output logic       fclr_filt
);
  logic [NUM_CH-1:0] raw_v, smp_v, filt_v;

  assign raw_v = {fclr_raw, en_raw, lo_cmd_raw, hi_cmd_raw};

  in_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_v), .q(smp_v)
  );

  for (genvar ch = 0; ch < int'(NUM_CH); ch++) begin : g_chan
    localparam int unsigned LEN = chan_len(ch, CMD_LEN, CTL_LEN);
    glitch_filter #(.LEN(LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .smp(smp_v[ch]), .q(filt_v[ch])
    );
  end

  assign hi_cmd    = filt_v[2:0];
  assign lo_cmd    = filt_v[5:3];
  assign en_filt   = filt_v[6];
  assign fclr_filt = filt_v[7];

  // R7
  single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(raw_v) == '0 && $past(smp_v) == '0 && $past(filt_v) == '0) |->
      $countones(filt_v) == 0);
endmodule

// File: tb/test_gate_input_conditioner.sv
module test_gate_input_conditioner;
  localparam int CMD = 27;
  localparam int CTL = 5;
  localparam int SYN = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] raw = '0;
  logic [2:0] hi_o, lo_o;
  logic en_o, fc_o;
  logic [7:0] outv;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  gate_input_conditioner #(.CMD_LEN(CMD), .CTL_LEN(CTL), .SYNC_STAGES(SYN))
    i_gate_input_conditioner (
    .clk(clk), .rst_n(rst_n),
    .hi_cmd_raw(raw[2:0]), .lo_cmd_raw(raw[5:3]), .en_raw(raw[6]), .fclr_raw(raw[7]),
    .hi_cmd(hi_o), .lo_cmd(lo_o), .en_filt(en_o), .fclr_filt(fc_o));

  assign outv = {fc_o, en_o, lo_o, hi_o};

  function automatic int len_of(int ch);
    if (ch >= 6) return CTL;
    return CMD;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse of width w on channel ch; returns output-high cycles and stray activity
  task automatic pulse(int ch, int w, output int hi_cnt, output int stray);
    int n = w + len_of(ch) + SYN + 4;
    hi_cnt = 0; stray = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      raw[ch] = (k < w);
      if (outv[ch]) hi_cnt++;
      if ((outv & ~(8'b1 << ch)) != 0) stray++;
    end
  endtask

  localparam int NV = 8;
  localparam int VCH [NV] = '{0, 0, 1, 3, 5, 6, 6, 7};
  localparam int VW  [NV] = '{26, 27, 40, 27, 1, 4, 5, 9};

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int hc, st, first;
    // R1: inputs high during reset
    raw = 8'hFF;
    repeat (5) @(negedge clk);
    check("R1 outputs in reset", outv, 0);
    raw = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", outv, 0);
    repeat (4) @(negedge clk);

    // table: R2 R3 R4 R7
    for (int v = 0; v < NV; v++) begin
      pulse(VCH[v], VW[v], hc, st);
      check((VCH[v] >= 6) ? "R4 ctl width" : (VW[v] < CMD ? "R2 reject" : "R3 width"),
            hc, (VW[v] >= len_of(VCH[v])) ? VW[v] : 0);
      check("R7 other channels quiet", st, 0);
    end

    // R5 latency rise and fall, command and control
    for (int c = 0; c < 2; c++) begin
      int ch = (c == 0) ? 4 : 6;
      first = -1;
      for (int k = 0; k < len_of(ch) + SYN + 6; k++) begin
        @(negedge clk);
        raw[ch] = 1'b1;
        if (outv[ch] && first < 0) first = k;
      end
      check("R5 rise delay", first, len_of(ch) + SYN);
      first = -1;
      for (int k = 0; k < len_of(ch) + SYN + 6; k++) begin
        @(negedge clk);
        raw[ch] = 1'b0;
        if (!outv[ch] && first < 0) first = k;
      end
      check("R5 fall delay", first, len_of(ch) + SYN);
    end

    // R6 noise trains
    for (int c = 0; c < 2; c++) begin
      int ch = (c == 0) ? 2 : 7;
      int per = len_of(ch);
      hc = 0;
      for (int k = 0; k < per * 6 + SYN + 4; k++) begin
        @(negedge clk);
        raw[ch] = (k < per * 6) && ((k % per) != per - 1);
        if (outv[ch]) hc++;
      end
      check("R6 noise train rejected", hc, 0);
    end

    // R1 reset while outputs high
    raw = 8'hFF;
    repeat (CMD + SYN + 4) @(negedge clk);
    check("R1 setup all high", outv, 8'hFF);
    rst_n = 0;
    @(negedge clk);
    check("R1 reset clears", outv, 0);
    raw = '0;
    rst_n = 1;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule